// File: doc/BRIEF.md
# Descriptor Ring Producer with Lap Stamping

This block accepts fixed-size descriptors of eight 32-bit words on a valid/ready input and commits each one, in a single clock edge, into the next slot of a circular ring held in on-chip registers. As it writes the last word of each descriptor, it replaces the top nibble of that word with a lap stamp. The stamp is a four-bit count of how many times the producer has wrapped around the ring, plus one. The first pass is therefore stamped 1. Slots cleared at reset hold 0, so they are never mistaken for fresh entries.

The consumer side owns a read pointer and an expected-parity bit. The parity bit starts at 1 and flips each time the read pointer wraps. The entry under the read pointer is reported valid when the least significant bit of its stamp matches that parity, so the consumer never has to look at the producer's write pointer. A descriptor that carries the error flag (word 2, bit 31) keeps its top nibble untouched, because there the field is an error code. For such an entry, validity comes from a one-bit pass record kept per slot. The consumer reads any word of its head entry through a word-select input and retires the entry with an advance strobe.

Top module: `desc_ring_producer`

## Requirements
- R1: While reset is applied and just after it: every ring word reads 0, `lap_count` is 0, `in_ready` is 1, `head_valid` is 0 and `new_entry` is 0.
- R2: `lap_count` increments by one at each accepted descriptor written into the last slot (slot SLOTS-1, after which writing resumes at slot 0). It wraps from 15 to 0 and is otherwise unchanged.
- R3: For a descriptor without the error flag, words 0 to 6 and bits [27:0] of word 7 are stored unchanged. Bits [31:28] of word 7 become (`lap_count` + 1) mod 16, using the value `lap_count` has at the moment of the write.
- R4: A descriptor whose word 2 bit 31 is set is stored with all eight words unchanged, including bits [31:28] of word 7.
- R5: All eight words of an accepted descriptor (word k on `in_desc[32k+31:32k]`) are written at the same clock edge. They become readable through the read port from the following cycle.
- R6: `in_ready` is low exactly when the slot after the write pointer equals the consumer slot, so at most SLOTS-1 entries are outstanding.
- R7: The consumer's expected parity is 1 after reset and flips whenever the consumer advances out of the last slot. `head_valid` is high when bit 28 of word 7 of the head slot equals that parity. For a head entry with the error flag set, the comparison uses instead the stamp parity recorded for that slot at commit.
- R8: `new_entry` is high for exactly the one cycle after each accepted descriptor.
- R9: `cons_adv` has no effect while `head_valid` is low: the head slot, and so `rd_data`, stays the same.
- R10: `rd_data` shows word `rd_word` of the head slot, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears ring, pointers and counters |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Ring has a free slot |
| in_desc | input | 256 | Descriptor, word k in bits [32k+31:32k] |
| new_entry | output | 1 | One-cycle pulse after each committed descriptor |
| rd_word | input | 3 | Word select within the head entry |
| rd_data | output | 32 | Selected word of the head entry |
| head_valid | output | 1 | Head entry belongs to the consumer's current pass |
| cons_adv | input | 1 | Retire the head entry (taken only when head_valid is high) |
| lap_count | output | 4 | Producer wrap counter |

## Verification
The write pointer, ring contents, lap counter and consumer pointer all change at the clock edge that accepts a handshake. The data-side results (`rd_data`, `head_valid`, `in_ready`) follow combinationally in the next cycle, and `new_entry` rises in that same cycle, one register after the accepting edge. The bench steps a behavioural model once per clock, using the inputs it has just driven. It then compares every output at the following falling edge, which is exactly when each result is due. The run covers long random traffic, a producer-only phase that fills the ring, and a consumer-only phase that drains it and then strobes against an empty ring. It also mixes in error-flagged descriptors and runs enough laps to roll the counter past 15.

// File: rtl/desc_ring_producer.sv
module desc_ring_producer #(
  parameter int SLOT_BITS = 3,
  parameter int WORD_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [8*WORD_W-1:0] in_desc,
  output logic                new_entry,
  input  logic [2:0]          rd_word,
  output logic [WORD_W-1:0]   rd_data,
  output logic                head_valid,
  input  logic                cons_adv,
  output logic [3:0]          lap_count
);
  localparam int SLOTS  = 1 << SLOT_BITS;
  localparam int NWORDS = 8;
  localparam int DESC_W = NWORDS * WORD_W;
  localparam int ERR_BIT = 2 * WORD_W + WORD_W - 1;
  localparam logic [SLOT_BITS-1:0] LAST = SLOT_BITS'(SLOTS - 1);

  logic [WORD_W-1:0]    ring [SLOTS][NWORDS];
  logic [SLOTS-1:0]     pass_bit;
  logic [SLOT_BITS-1:0] wr_ptr, cons_ptr;
  logic [3:0]           lap;
  logic                 exp_par, new_q;

  wire [SLOT_BITS-1:0] wr_nxt = wr_ptr + 1'b1;
  wire                 push   = in_valid & in_ready;
  wire                 is_err = in_desc[ERR_BIT];
  wire [3:0]           stamp  = lap + 4'd1;
  wire [WORD_W-1:0]    tail_w = is_err ? in_desc[DESC_W-1 -: WORD_W]
                                       : {stamp, in_desc[DESC_W-5 -: WORD_W-4]};

  wire [WORD_W-1:0] head_tail = ring[cons_ptr][NWORDS-1];
  wire              head_err  = ring[cons_ptr][2][WORD_W-1];
  wire              head_par  = head_err ? pass_bit[cons_ptr] : head_tail[WORD_W-4];
  wire              pop       = cons_adv & head_valid;

  assign in_ready   = (wr_nxt != cons_ptr);
  assign head_valid = (head_par == exp_par);
  assign rd_data    = ring[cons_ptr][rd_word];
  assign new_entry  = new_q;
  assign lap_count  = lap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int w = 0; w < NWORDS; w++)
          ring[s][w] <= '0;
      pass_bit <= '0;
      wr_ptr   <= '0;
      cons_ptr <= '0;
      lap      <= '0;
      exp_par  <= 1'b1;
      new_q    <= 1'b0;
    end else begin
      new_q <= push;
      if (push) begin
        for (int w = 0; w < NWORDS - 1; w++)
          ring[wr_ptr][w] <= in_desc[w*WORD_W +: WORD_W];
        ring[wr_ptr][NWORDS-1] <= tail_w;
        pass_bit[wr_ptr]       <= ~lap[0];
        wr_ptr                 <= wr_nxt;
        if (wr_ptr == LAST) lap <= lap + 4'd1;
      end
      if (pop) begin
        cons_ptr <= cons_ptr + 1'b1;
        if (cons_ptr == LAST) exp_par <= ~exp_par;
      end
    end
  end
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int SLOT_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 new_entry,
  input logic                 cons_adv,
  input logic                 head_valid,
  input logic [SLOT_BITS-1:0] wr_ptr,
  input logic [SLOT_BITS-1:0] cons_ptr,
  input logic [3:0]           lap,
  input logic                 exp_par
);
  localparam logic [SLOT_BITS-1:0] LAST = SLOT_BITS'((1 << SLOT_BITS) - 1);

  assert_pulse_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> new_entry);
  assert_pulse_needs_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    new_entry |-> $past(in_valid && in_ready));
  assert_lap_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && wr_ptr == LAST) |=> lap == $past(lap) + 4'd1);
  assert_lap_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && wr_ptr == LAST) |=> $stable(lap));
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> wr_ptr != cons_ptr);
  assert_ignore_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_adv && !head_valid) |=> $stable(cons_ptr) && $stable(exp_par));
  assert_parity_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_adv && head_valid && cons_ptr == LAST) |=> exp_par != $past(exp_par));
endmodule

bind desc_ring_producer desc_ring_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (.*);

// File: tb/tb_desc_ring_producer.sv
module tb_desc_ring_producer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_desc = '0;
  logic         new_entry;
  logic [2:0]   rd_word = '0;
  logic [31:0]  rd_data;
  logic         head_valid;
  logic         cons_adv = 1'b0;
  logic [3:0]   lap_count;

  desc_ring_producer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_mem [SLOTS][8];
  bit          m_pass [SLOTS];
  int          m_wp, m_cp, m_lap;
  bit          m_ep, m_pulse;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_head_valid();
    bit par = m_mem[m_cp][2][31] ? m_pass[m_cp] : m_mem[m_cp][7][28];
    return par == m_ep;
  endfunction

  function automatic bit m_ready();
    return ((m_wp + 1) % SLOTS) != m_cp;
  endfunction

  task automatic compare();
    check("R6 in_ready", 32'(in_ready), 32'(m_ready()));
    check("R7 head_valid", 32'(head_valid), 32'(m_head_valid()));
    check("R10/R3/R4/R5 rd_data", rd_data, m_mem[m_cp][rd_word]);
    check("R8 new_entry", 32'(new_entry), 32'(m_pulse));
    check("R2 lap_count", 32'(lap_count), 32'(m_lap));
  endtask

  task automatic step(int p_push, int p_pop, int p_err);
    bit push, pop, hv;
    @(negedge clk);
    compare();
    in_valid = ($urandom_range(99) < p_push);
    for (int w = 0; w < 8; w++) in_desc[w*32 +: 32] = $urandom;
    in_desc[95] = ($urandom_range(99) < p_err);
    cons_adv = ($urandom_range(99) < p_pop);
    rd_word  = 3'($urandom_range(7));
    hv   = m_head_valid();
    push = in_valid && m_ready();
    pop  = cons_adv && hv;
    m_pulse = push;
    if (push) begin
      for (int w = 0; w < 8; w++) m_mem[m_wp][w] = in_desc[w*32 +: 32];
      if (!in_desc[95]) m_mem[m_wp][7][31:28] = 4'((m_lap + 1) % 16);
      m_pass[m_wp] = ((m_lap + 1) % 2) == 1;
      if (m_wp == SLOTS - 1) m_lap = (m_lap + 1) % 16;
      m_wp = (m_wp + 1) % SLOTS;
    end
    if (pop) begin
      if (m_cp == SLOTS - 1) m_ep = ~m_ep;
      m_cp = (m_cp + 1) % SLOTS;
    end
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      m_pass[s] = 0;
      for (int w = 0; w < 8; w++) m_mem[s][w] = '0;
    end
    m_wp = 0; m_cp = 0; m_lap = 0; m_ep = 1; m_pulse = 0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    check("R1 in_ready", 32'(in_ready), 32'd1);
    check("R1 head_valid", 32'(head_valid), 32'd0);
    check("R1 new_entry", 32'(new_entry), 32'd0);
    check("R1 lap_count", 32'(lap_count), 32'd0);
    for (int w = 0; w < 8; w++) begin
      rd_word = 3'(w);
      #1 check("R1 ring word", rd_data, 32'd0);
    end
    rd_word = '0;
    rst_n = 1'b1;
    repeat (600)  step(70, 60, 10);
    repeat (60)   step(95, 0, 10);   // fill: R6 backpressure
    repeat (60)   step(0, 90, 10);   // drain, then strobes on empty ring: R9
    repeat (2800) step(80, 75, 15);  // many laps: R2 rollover, R3, R4, R7
    repeat (40)   step(100, 0, 50);
    repeat (40)   step(0, 100, 50);
    @(negedge clk);
    compare();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule